// File: doc/BRIEF.md
# Background Pixel Shifter with Fine Horizontal Scroll

This block sits behind a tile fetch engine in a raster video pipeline. Each tile row arrives as two pattern bytes, one per bit plane, plus an attribute byte. The block turns them into a stream of 2-bit background colour indices, one per dot, together with a 2-bit palette select. Each pattern plane has a 16-bit shift register. The newest tile enters the lower half, and the upper half feeds the output. A 3-bit fine horizontal scroll value picks which bit position of the upper half is sampled, so the picture can be offset by zero to seven pixels without changing the fetch sequence.

The block decodes the current dot number of the scanline (0 to 340) and a rendering-enable flag to decide when to shift and when to reload. Two tiles are preloaded near the end of a line, on dots 329 and 337, so that dots 1 to 16 of the next line have data. From dot 9 onward, a new tile enters every eight dots while the previous one is being drawn. The palette select for each tile is taken from one 2-bit field of the attribute byte, held in a one-tile latch, and pushed through two 8-bit shifters. These run in step with the pattern planes, so every pixel carries the palette of the tile it came from.

Top module: `bg_fine_shifter`

## Requirements
- R1: After reset every shifter and the palette latch are zero, so `pix_idx` and `pix_pal` read 0 for every `fine_x`.
- R2: State advances by one position only on clocks where `render_en` is 1 and `dot` lies in 2..257 or 322..337. On every other clock, including all clocks with `render_en` 0, the output for any given `fine_x` keeps its value.
- R3: A reload happens when `render_en` is 1 and `dot` is 9, 17, ..., 257, 329 or 337 (dot mod 8 equal to 1). `pat_lo` and `pat_hi` enter the lower byte of their shifters, bit 7 being the leftmost pixel. On the same clock the upper byte takes the shifted contents.
- R4: `pix_idx` is {high-plane bit, low-plane bit} taken from register bit 15 - `fine_x`. `fine_x` = 0 samples the top bit, and each increment samples one bit lower.
- R5: With `fine_x` = 0, the tile reloaded on dot 9 is output starting on dot 17, its bit 7 first.
- R6: Pixels on dots 1..16 come from the tiles reloaded on dots 329 and 337 of the previous line, in that order.
- R7: At each reload the palette latch takes the 2-bit field of `attr_byte` that starts at bit 4*`coarse_y1` + 2*`coarse_x1`.
- R8: `pix_pal` is the latched palette of the tile that supplies the current `pix_idx`, for every `fine_x`, including pixels that straddle a tile boundary.
- R9: A change of `fine_x` alone changes the outputs on the same clock and alters no stored state. Restoring the earlier `fine_x` restores the earlier output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| render_en | input | 1 | Background rendering enabled |
| dot | input | 9 | Current dot within the scanline, 0..340 |
| fine_x | input | 3 | Fine horizontal scroll, selects the output tap |
| pat_lo | input | 8 | Fetched low-plane pattern byte, bit 7 leftmost |
| pat_hi | input | 8 | Fetched high-plane pattern byte, bit 7 leftmost |
| attr_byte | input | 8 | Fetched attribute byte holding four 2-bit palette fields |
| coarse_x1 | input | 1 | Bit 1 of the coarse horizontal tile position |
| coarse_y1 | input | 1 | Bit 1 of the coarse vertical tile position |
| pix_idx | output | 2 | Background colour index, high plane as MSB |
| pix_pal | output | 2 | Palette select of the tile supplying the pixel |

## Verification
A wrong reload dot or a missed shift moves the whole line sideways. This shows up on `pix_idx` within eight dots, because the next tile boundary lands on the wrong dot. A fault in the attribute latch or its shifters leaves `pix_idx` correct and makes `pix_pal` wrong only near tile edges at some `fine_x` values, so those edges are checked at all eight scroll settings. A shift during blanking or with rendering off shows at once as an output that changes on a dot where it should hold.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
   localparam int PAL_W  = 2;
   localparam int PLANES = 2;

   // Pick one 2-bit palette field out of an attribute byte by quadrant.
   function automatic logic [PAL_W-1:0] quad_pick(input logic [7:0] ab,
                                                  input logic cx,
                                                  input logic cy);
      logic [PAL_W-1:0] r;
      unique case ({cy, cx})
         2'b00:   r = ab[1:0];
         2'b01:   r = ab[3:2];
         2'b10:   r = ab[5:4];
         default: r = ab[7:6];
      endcase
      return r;
   endfunction
endpackage

// File: rtl/bgs_timing.sv
module bgs_timing #(
   parameter int TILE_W        = 8,
   parameter int DOT_W         = 9,
   parameter int SHIFT_A_FIRST = 2,
   parameter int SHIFT_A_LAST  = 257,
   parameter int SHIFT_B_FIRST = 322,
   parameter int SHIFT_B_LAST  = 337,
   parameter int LOAD_A_FIRST  = 9,
   parameter int LOAD_B_FIRST  = 329
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             render_en,
   input  logic [DOT_W-1:0] dot,
   output logic             shift_en,
   output logic             load_en
);
   localparam int PH_W = $clog2(TILE_W);
   localparam logic [DOT_W-1:0] SA_F = DOT_W'(SHIFT_A_FIRST);
   localparam logic [DOT_W-1:0] SA_L = DOT_W'(SHIFT_A_LAST);
   localparam logic [DOT_W-1:0] SB_F = DOT_W'(SHIFT_B_FIRST);
   localparam logic [DOT_W-1:0] SB_L = DOT_W'(SHIFT_B_LAST);
   localparam logic [DOT_W-1:0] LA_F = DOT_W'(LOAD_A_FIRST);
   localparam logic [DOT_W-1:0] LB_F = DOT_W'(LOAD_B_FIRST);
   localparam logic [PH_W-1:0]  PHASE = PH_W'(LOAD_A_FIRST % TILE_W);

   if (LOAD_A_FIRST % TILE_W != LOAD_B_FIRST % TILE_W) begin : g_bad_phase
      $error("reload windows must share one tile phase");
   end
   if (LOAD_A_FIRST < SHIFT_A_FIRST || LOAD_B_FIRST < SHIFT_B_FIRST) begin : g_bad_win
      $error("reload windows must lie inside shift windows");
   end

   logic in_a, in_b, on_phase;
   always_comb begin
      in_a     = (dot >= SA_F) && (dot <= SA_L);
      in_b     = (dot >= SB_F) && (dot <= SB_L);
      on_phase = (dot[PH_W-1:0] == PHASE);
      shift_en = render_en && (in_a || in_b);
      load_en  = render_en && on_phase &&
                 (((dot >= LA_F) && (dot <= SA_L)) || ((dot >= LB_F) && (dot <= SB_L)));
   end

   // R3: every reload dot is also a shift dot, so the upper byte always advances
   assert_reload_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |-> shift_en);
   // R2: nothing moves while rendering is off
   assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !render_en |-> !shift_en && !load_en);
endmodule

// File: rtl/bgs_plane.sv
module bgs_plane #(
   parameter int W  = 16,
   parameter int LW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          shift,
   input  logic          load,
   input  logic          sin,
   input  logic [LW-1:0] ld_data,
   output logic [W-1:0]  q
);
   if (LW < 1 || LW >= W) begin : g_bad_w
      $error("plane load width must be between 1 and W-1");
   end

   logic [W-1:0] nxt;
   always_comb begin
      nxt = q;
      if (shift) nxt = {q[W-2:0], sin};
      if (load)  nxt[LW-1:0] = ld_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

   // R2: without shift or reload the plane holds
   assert_plane_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !shift && !load |=> $stable(q));
   // R3: a reload never disturbs the upper part beyond the one-step shift
   assert_upper_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load && !shift |=> q[W-1:LW] == $past(q[W-1:LW]));
endmodule

// File: rtl/bgs_tap.sv
module bgs_tap #(
   parameter int W      = 16,
   parameter int SEL_W  = 3,
   parameter int OFFSET = 0
) (
   input  logic [W-1:0]     vec,
   input  logic [SEL_W-1:0] sel,
   output logic             bit_o
);
   localparam int NSEL = 1 << SEL_W;
   if (W - 1 - OFFSET - (NSEL - 1) < 0) begin : g_bad_tap
      $error("tap range exceeds vector");
   end

   always_comb begin
      bit_o = 1'b0;
      for (int i = 0; i < NSEL; i++) begin
         if (sel == SEL_W'(i)) bit_o = vec[W-1-OFFSET-i];
      end
   end
endmodule

// File: rtl/bg_fine_shifter.sv
module bg_fine_shifter import bgs_pkg::*; #(
   parameter int TILE_W        = 8,
   parameter int DOT_W         = 9,
   parameter int SHIFT_A_FIRST = 2,
   parameter int SHIFT_A_LAST  = 257,
   parameter int SHIFT_B_FIRST = 322,
   parameter int SHIFT_B_LAST  = 337,
   parameter int LOAD_A_FIRST  = 9,
   parameter int LOAD_B_FIRST  = 329,
   localparam int FX_W         = $clog2(TILE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              render_en,
   input  logic [DOT_W-1:0]  dot,
   input  logic [FX_W-1:0]   fine_x,
   input  logic [TILE_W-1:0] pat_lo,
   input  logic [TILE_W-1:0] pat_hi,
   input  logic [7:0]        attr_byte,
   input  logic              coarse_x1,
   input  logic              coarse_y1,
   output logic [1:0]        pix_idx,
   output logic [PAL_W-1:0]  pix_pal
);
   localparam int SHIFT_W = 2 * TILE_W;

   if (TILE_W < 2 || (TILE_W & (TILE_W - 1)) != 0) begin : g_bad_tile
      $error("TILE_W must be a power of two of at least 2");
   end
   if ((1 << DOT_W) <= SHIFT_B_LAST) begin : g_bad_dot
      $error("DOT_W too narrow for the dot range");
   end

   logic shift_en, load_en;

   bgs_timing #(
      .TILE_W(TILE_W), .DOT_W(DOT_W),
      .SHIFT_A_FIRST(SHIFT_A_FIRST), .SHIFT_A_LAST(SHIFT_A_LAST),
      .SHIFT_B_FIRST(SHIFT_B_FIRST), .SHIFT_B_LAST(SHIFT_B_LAST),
      .LOAD_A_FIRST(LOAD_A_FIRST), .LOAD_B_FIRST(LOAD_B_FIRST)
   ) u_timing (
      .clk(clk), .rst_n(rst_n), .render_en(render_en), .dot(dot),
      .shift_en(shift_en), .load_en(load_en)
   );

   // Palette latch: one tile's palette select, refreshed at each reload (R7)
   logic [PAL_W-1:0] pal_latch;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pal_latch <= '0;
      else if (load_en) pal_latch <= quad_pick(attr_byte, coarse_x1, coarse_y1);
   end

   logic [PLANES-1:0][TILE_W-1:0]  pat_in;
   logic [PLANES-1:0][SHIFT_W-1:0] pq;
   logic [PLANES-1:0][TILE_W-1:0]  aq;
   logic [PLANES-1:0]              idx_bit, pal_bit, below_bit;

   assign pat_in[0] = pat_lo;
   assign pat_in[1] = pat_hi;

   for (genvar p = 0; p < PLANES; p++) begin : g_plane
      bgs_plane #(.W(SHIFT_W), .LW(TILE_W)) u_pat (
         .clk(clk), .rst_n(rst_n), .shift(shift_en), .load(load_en),
         .sin(1'b0), .ld_data(pat_in[p]), .q(pq[p])
      );
      bgs_plane #(.W(TILE_W), .LW(1)) u_attr (
         .clk(clk), .rst_n(rst_n), .shift(shift_en), .load(1'b0),
         .sin(pal_latch[p]), .ld_data(1'b0), .q(aq[p])
      );
      bgs_tap #(.W(SHIFT_W), .SEL_W(FX_W), .OFFSET(0)) u_tap_pat (
         .vec(pq[p]), .sel(fine_x), .bit_o(idx_bit[p])
      );
      bgs_tap #(.W(TILE_W), .SEL_W(FX_W), .OFFSET(0)) u_tap_attr (
         .vec(aq[p]), .sel(fine_x), .bit_o(pal_bit[p])
      );
      bgs_tap #(.W(SHIFT_W), .SEL_W(FX_W), .OFFSET(1)) u_tap_below (
         .vec(pq[p]), .sel(fine_x), .bit_o(below_bit[p])
      );
   end

   assign pix_idx = {idx_bit[1], idx_bit[0]};
   assign pix_pal = {pal_bit[1], pal_bit[0]};

   // R2: rendering off freezes every stored bit
   assert_frozen_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !render_en |=> $stable(pq) && $stable(aq) && $stable(pal_latch));
   // R3: reloaded bytes land in the lower half of the pattern planes
   assert_reload_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> pq[0][TILE_W-1:0] == $past(pat_lo) && pq[1][TILE_W-1:0] == $past(pat_hi));
   // R4: after a shift at unchanged scroll, the output is the bit that sat one tap lower
   assert_tap_advances_R4: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> (fine_x != $past(fine_x)) || (pix_idx == $past(below_bit)));
   // R8: each shift pushes the latched palette into the attribute shifters
   assert_pal_feed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> aq[0][0] == $past(pal_latch[0]) && aq[1][0] == $past(pal_latch[1]));
endmodule

// File: tb/bg_fine_shifter_test.sv
module bg_fine_shifter_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       render_en = 1'b0;
   logic [8:0] dot = '0;
   logic [2:0] fine_x = '0;
   logic [7:0] pat_lo = '0, pat_hi = '0, attr_byte = '0;
   logic       coarse_x1 = 1'b0, coarse_y1 = 1'b0;
   logic [1:0] pix_idx, pix_pal;

   int n_run = 0;
   int n_fail = 0;

   bg_fine_shifter uut (
      .clk(clk), .rst_n(rst_n), .render_en(render_en), .dot(dot), .fine_x(fine_x),
      .pat_lo(pat_lo), .pat_hi(pat_hi), .attr_byte(attr_byte),
      .coarse_x1(coarse_x1), .coarse_y1(coarse_y1),
      .pix_idx(pix_idx), .pix_pal(pix_pal)
   );

   always #4ns clk = ~clk;

   // Stream model: entry j ahead of head is the pixel at tap j
   logic [1:0] sp [4096];
   logic [1:0] sa [4096];
   int         head = 0;
   logic [1:0] mlatch = '0;

   // Tile model for line-cadence checks
   logic [7:0] tlo [34], thi [34];
   logic [1:0] tpal [34];
   logic [7:0] nlo [2], nhi [2];
   logic [1:0] npal [2];

   function automatic logic [1:0] exp_quad(input logic [7:0] ab, input logic cx, input logic cy);
      int sh;
      sh = 4 * int'(cy) + 2 * int'(cx);
      return 2'((ab >> sh) & 8'h3);
   endfunction

   function automatic bit is_shift(input int d, input bit ren);
      return ren && ((d >= 2 && d <= 257) || (d >= 322 && d <= 337));
   endfunction

   function automatic bit is_load(input int d, input bit ren);
      return ren && (d % 8 == 1) && ((d >= 9 && d <= 257) || (d >= 329 && d <= 337));
   endfunction

   task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s dot=%0d fx=%0d got pal/idx=%0h expected %0h", req, dot, fine_x, got, exp);
      end
   endtask

   function automatic logic [3:0] stream_exp(input int fx);
      return {sa[(head + fx) & 4095], sp[(head + fx) & 4095]};
   endfunction

   // Drive one dot, clock it, update both models
   task automatic step(input int d, input bit ren, input int fx);
      logic [7:0] lo, hi, ab;
      logic cx, cy;
      logic [1:0] q;
      lo = 8'($urandom); hi = 8'($urandom); ab = 8'($urandom);
      cx = 1'($urandom); cy = 1'($urandom);
      @(negedge clk);
      dot = 9'(d); render_en = ren; fine_x = 3'(fx);
      pat_lo = lo; pat_hi = hi; attr_byte = ab; coarse_x1 = cx; coarse_y1 = cy;
      @(posedge clk);
      q = exp_quad(ab, cx, cy);
      if (is_shift(d, ren)) begin
         head++;
         sa[(head + 7) & 4095]  = mlatch;
         sp[(head + 15) & 4095] = 2'b00;
      end
      if (is_load(d, ren)) begin
         for (int i = 0; i < 8; i++) sp[(head + 8 + i) & 4095] = {hi[7-i], lo[7-i]};
         mlatch = q;
         if (d >= 329) begin
            nlo[(d - 329) / 8] = lo; nhi[(d - 329) / 8] = hi; npal[(d - 329) / 8] = q;
         end else begin
            tlo[2 + (d - 9) / 8] = lo; thi[2 + (d - 9) / 8] = hi; tpal[2 + (d - 9) / 8] = q;
         end
      end
      #1ns;
   endtask

   task automatic run_line(input int fx);
      for (int d = 0; d <= 340; d++) begin
         if (d == 0) begin
            for (int k = 0; k < 2; k++) begin
               tlo[k] = nlo[k]; thi[k] = nhi[k]; tpal[k] = npal[k];
            end
         end
         step(d, 1'b1, fx);
         if (d >= 1 && d <= 256) begin
            int p, t, b;
            logic [3:0] e;
            p = (d - 1) + fx; t = p / 8; b = 7 - (p % 8);
            e = {tpal[t], thi[t][b], tlo[t][b]};
            if (d <= 16)                  chk("R6 prefetched tiles", {pix_pal, pix_idx}, e);
            else if (d == 17 && fx == 0)  chk("R5 dot-9 tile on dot 17", {pix_pal, pix_idx}, e);
            else                          chk("R4/R8 line pixel", {pix_pal, pix_idx}, e);
         end
      end
   endtask

   initial begin
      #1600000ns;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [3:0] saved [8];
      void'($urandom(32'd20240611));
      for (int i = 0; i < 4096; i++) begin sp[i] = '0; sa[i] = '0; end
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1; dot = 9'd300;

      // R1: reset state at every tap
      for (int fx = 0; fx < 8; fx++) begin
         @(negedge clk); fine_x = 3'(fx); #1ns;
         chk("R1 reset output", {pix_pal, pix_idx}, 4'h0);
      end

      // Prefetch tail of a line, then full lines at every fine scroll (R4 R5 R6 R7 R8)
      for (int d = 321; d <= 340; d++) step(d, 1'b1, 0);
      for (int fx = 0; fx < 8; fx++) run_line(fx);
      run_line(0);
      run_line(7);

      // R2: a whole line with rendering off leaves every tap unchanged
      for (int fx = 0; fx < 8; fx++) begin
         @(negedge clk); fine_x = 3'(fx); #1ns;
         saved[fx] = {pix_pal, pix_idx};
      end
      for (int d = 0; d <= 340; d++) step(d, 1'b0, d % 8);
      for (int fx = 0; fx < 8; fx++) begin
         @(negedge clk); fine_x = 3'(fx); #1ns;
         chk("R2 frozen with render off", {pix_pal, pix_idx}, saved[fx]);
      end

      // R2: blanking dots with rendering on do not shift either
      for (int d = 258; d <= 321; d++) begin
         step(d, 1'b1, 3);
         chk("R2 blanking hold", {pix_pal, pix_idx}, stream_exp(3));
      end

      // R9: scroll sweep on a non-shift dot, forward and back
      for (int r = 0; r < 2; r++) begin
         for (int fx = 0; fx < 8; fx++) begin
            step(300, 1'b1, (r == 0) ? fx : 7 - fx);
            chk("R9 scroll-only change", {pix_pal, pix_idx}, stream_exp((r == 0) ? fx : 7 - fx));
         end
      end

      // Random dots, enables and scroll against the stream model (R3 R4 R7 R8)
      for (int n = 0; n < 6000; n++) begin
         int d, fx;
         bit ren;
         d   = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 340))
                                           : int'($urandom_range(0, 42)) * 8 + 1;
         if (d > 340) d = 337;
         ren = ($urandom_range(0, 3) != 0);
         fx  = int'($urandom_range(0, 7));
         step(d, ren, fx);
         chk("R3/R7 random dot", {pix_pal, pix_idx}, stream_exp(fx));
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule